// File: doc/BRIEF.md
# I2C Register Target with Event Freeze

This block is a target on a two-wire I2C-compatible bus. It samples SCL and SDA on a fast system clock, detects START, repeated START and STOP, answers one fixed 7-bit address, and gives the host a small bank of byte registers. The first data byte of a write sets an 8-bit register pointer. Any further bytes are stored at that pointer, which advances after each one. A read begins with a write phase that sets the pointer. The host then sends a repeated START and the address with the read bit set, and the target shifts bytes out MSB first.

A producer elsewhere on the chip posts 8-bit key events. They collect in an event FIFO, and the host sees how many are stored and pops them over the bus. Once a transaction has touched the event count or the pop register, producer events do not enter the FIFO until the bus STOP. Up to four of them wait in a small pending queue and are committed in arrival order right after the STOP. An event that finds the pending queue full is dropped and raises a sticky overflow flag.

Top module: `i2c_evt_target`

## Requirements
- R1: The target acknowledges (drives SDA low through the ninth clock) only the address 0x34. Any other address gets no acknowledge, and the target stays silent until the next START.
- R2: In a write, the byte after the address sets the pointer, and every following data byte is acknowledged, stored at the pointer, and advances the pointer by one.
- R3: In a read, the target sends the register at the pointer MSB first. After each byte the host acknowledges, the pointer advances and the next byte follows. A host NACK ends the read.
- R4: The pointer wraps from 0xFF to 0x00.
- R5: Register map. 0x00 reads the number of stored events and ignores writes. 0x01 pops and returns the oldest event, or 0x00 when the FIFO is empty. 0x10 to 0x17 are read/write bytes, and byte i drives `ctrl_q[8*i+7:8*i]`. Every other address reads 0x00 and ignores writes.
- R6: Once a transaction sets the pointer to, stores at, or reads from 0x00 or 0x01, producer events are not committed to the FIFO until STOP. Outside that window they are committed within a few system clocks.
- R7: Up to 4 events wait while commits are held. An event that arrives with the pending queue full is dropped and sets `evt_ovf`, which stays set until reset.
- R8: Events are returned in the order they arrived, including those that were held and committed after a STOP.
- R9: After reset, SDA is released, all registers are zero, the FIFO is empty and `evt_ovf` is low.
- R10: A STOP at any point returns the target to idle with SDA released. A START at any point restarts address reception, and a partially received byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull SDA low |
| evt_valid | input | 1 | One-cycle strobe for a producer event |
| evt_data | input | 8 | Producer event code |
| evt_ovf | output | 1 | Sticky flag: an event was dropped |
| ctrl_q | output | 64 | Contents of the read/write register bank |

## Verification
The checker watches every cycle for four things. SDA is only ever pulled low while SCL is low. The target is silent when idle and after any STOP. The event count never grows while commits are held. Overflow rises whenever an event meets a full pending queue, and it never falls afterwards. What only the directed scenarios can show is the data content: address filtering, stored and returned bytes, pointer advance and wrap, FIFO order across a hold, and recovery from a STOP or START in the middle of a byte.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_ADDR, ST_ACK_ADR, ST_PTR, ST_ACK_PTR,
      ST_WDATA, ST_ACK_WR, ST_RDATA, ST_RACK
   } bus_st_e;

   localparam logic [7:0] ADDR_EVT_CNT = 8'h00;
   localparam logic [7:0] ADDR_EVT_POP = 8'h01;

   function automatic logic is_evt_addr(input logic [7:0] a);
      return (a == ADDR_EVT_CNT) || (a == ADDR_EVT_POP);
   endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_p    <= 1'b1;
         sda_p    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_p    <= scl_pipe[STAGES-1];
         sda_p    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_det = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_small_fifo.sv
module i2c_small_fifo #(
   parameter  int W     = 8,
   parameter  int DEPTH = 4,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("i2c_small_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && (count != '0);
   assign dout    = mem[rd_ptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_mod
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end
endmodule

// File: rtl/i2c_evt_queue.sv
module i2c_evt_queue #(
   parameter  int W          = 8,
   parameter  int FIFO_DEPTH = 8,
   parameter  int PEND_DEPTH = 4,
   localparam int CW         = $clog2(FIFO_DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          evt_valid,
   input  logic [W-1:0]  evt_data,
   input  logic          hold,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count,
   output logic          pend_full,
   output logic          ovf
);
   localparam int PCW = $clog2(PEND_DEPTH + 1);

   logic [W-1:0]   pend_dout, main_dout;
   logic [PCW-1:0] pend_cnt;
   logic           main_full, drain;

   assign drain = !hold && (pend_cnt != '0) && !main_full;

   i2c_small_fifo #(.W(W), .DEPTH(PEND_DEPTH)) u_pend (
      .clk(clk), .rst_n(rst_n),
      .push(evt_valid), .din(evt_data),
      .pop(drain), .dout(pend_dout),
      .count(pend_cnt), .full(pend_full)
   );

   i2c_small_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_main (
      .clk(clk), .rst_n(rst_n),
      .push(drain), .din(pend_dout),
      .pop(pop), .dout(main_dout),
      .count(count), .full(main_full)
   );

   assign head = (count != '0) ? main_dout : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      ovf <= 1'b0;
      else if (evt_valid && pend_full) ovf <= 1'b1;
   end
endmodule

// File: rtl/i2c_evt_target.sv
module i2c_evt_target #(
   parameter logic [6:0] DEV_ADDR    = 7'h34,
   parameter int         NREG        = 8,
   parameter int         REG_BASE    = 16,
   parameter int         FIFO_DEPTH  = 8,
   parameter int         PEND_DEPTH  = 4,
   parameter int         SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scl_i,
   input  logic            sda_i,
   output logic            sda_oe,
   input  logic            evt_valid,
   input  logic [7:0]      evt_data,
   output logic            evt_ovf,
   output logic [NREG*8-1:0] ctrl_q
);
   import i2c_evt_pkg::*;

   localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

   generate
      if (REG_BASE < 2 || REG_BASE + NREG > 256) begin : g_bad_map
         $error("i2c_evt_target: register bank must sit inside 0x02..0xFF");
      end
      if (FIFO_DEPTH > 255) begin : g_bad_fifo
         $error("i2c_evt_target: event count must fit in one byte");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   bus_st_e     state_q;
   logic [3:0]  bitcnt_q;
   logic [7:0]  shreg_q, txsh_q, ptr_q, rd_addr, rd_data;
   logic        oe_q, rw_q, nack_q, hold_q;
   logic        byte_done, wr_fire, load_fire, pop_req, touch_evt;
   logic [7:0]  evt_head;
   logic [CNT_W-1:0] fifo_cnt;
   logic        pend_full;

   i2c_evt_queue #(.W(8), .FIFO_DEPTH(FIFO_DEPTH), .PEND_DEPTH(PEND_DEPTH)) u_queue (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_data(evt_data),
      .hold(hold_q), .pop(pop_req), .head(evt_head), .count(fifo_cnt),
      .pend_full(pend_full), .ovf(evt_ovf)
   );

   // register bank, one generate block per byte
   genvar gi;
   generate
      for (gi = 0; gi < NREG; gi++) begin : g_reg
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   q <= '0;
            else if (wr_fire && ptr_q == 8'(REG_BASE + gi)) q <= shreg_q;
         end
         assign ctrl_q[8*gi +: 8] = q;
      end
   endgenerate

   assign byte_done = scl_fall && (bitcnt_q == 4'd8);
   assign wr_fire   = (state_q == ST_WDATA) && byte_done;
   assign load_fire = scl_fall && (((state_q == ST_ACK_ADR) && rw_q) ||
                                   ((state_q == ST_RACK) && !nack_q));
   assign rd_addr   = (state_q == ST_RACK) ? ptr_q + 8'd1 : ptr_q;
   assign pop_req   = load_fire && (rd_addr == ADDR_EVT_POP);
   assign touch_evt = ((state_q == ST_PTR) && byte_done && is_evt_addr(shreg_q)) ||
                      (wr_fire && is_evt_addr(ptr_q)) ||
                      (load_fire && is_evt_addr(rd_addr));

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_EVT_CNT)      rd_data = 8'(fifo_cnt);
      else if (rd_addr == ADDR_EVT_POP) rd_data = evt_head;
      else begin
         for (int i = 0; i < NREG; i++) begin
            if (rd_addr == 8'(REG_BASE + i)) rd_data = ctrl_q[8*i +: 8];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hold_q <= 1'b0;
      else if (stop_det)  hold_q <= 1'b0;
      else if (touch_evt) hold_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         bitcnt_q <= '0;
         shreg_q  <= '0;
         txsh_q   <= '0;
         ptr_q    <= '0;
         oe_q     <= 1'b0;
         rw_q     <= 1'b0;
         nack_q   <= 1'b0;
      end else if (start_det) begin
         state_q  <= ST_ADDR;
         bitcnt_q <= '0;
         oe_q     <= 1'b0;
      end else if (stop_det) begin
         state_q  <= ST_IDLE;
         oe_q     <= 1'b0;
      end else begin
         case (state_q)
            ST_ADDR, ST_PTR, ST_WDATA: begin
               if (scl_rise && bitcnt_q != 4'd8) begin
                  shreg_q  <= {shreg_q[6:0], sda_s};
                  bitcnt_q <= bitcnt_q + 4'd1;
               end
               if (byte_done) begin
                  bitcnt_q <= '0;
                  if (state_q == ST_ADDR) begin
                     if (shreg_q[7:1] == DEV_ADDR) begin
                        rw_q    <= shreg_q[0];
                        oe_q    <= 1'b1;
                        state_q <= ST_ACK_ADR;
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end else if (state_q == ST_PTR) begin
                     ptr_q   <= shreg_q;
                     oe_q    <= 1'b1;
                     state_q <= ST_ACK_PTR;
                  end else begin
                     ptr_q   <= ptr_q + 8'd1;
                     oe_q    <= 1'b1;
                     state_q <= ST_ACK_WR;
                  end
               end
            end
            ST_ACK_ADR: begin
               if (scl_fall) begin
                  if (rw_q) begin
                     txsh_q  <= rd_data;
                     oe_q    <= ~rd_data[7];
                     state_q <= ST_RDATA;
                  end else begin
                     oe_q    <= 1'b0;
                     state_q <= ST_PTR;
                  end
               end
            end
            ST_ACK_PTR, ST_ACK_WR: begin
               if (scl_fall) begin
                  oe_q    <= 1'b0;
                  state_q <= ST_WDATA;
               end
            end
            ST_RDATA: begin
               if (scl_fall) begin
                  if (bitcnt_q == 4'd7) begin
                     bitcnt_q <= '0;
                     oe_q     <= 1'b0;
                     state_q  <= ST_RACK;
                  end else begin
                     txsh_q   <= {txsh_q[6:0], 1'b0};
                     oe_q     <= ~txsh_q[6];
                     bitcnt_q <= bitcnt_q + 4'd1;
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) nack_q <= sda_s;
               if (scl_fall) begin
                  if (!nack_q) begin
                     ptr_q   <= rd_addr;
                     txsh_q  <= rd_data;
                     oe_q    <= ~rd_data[7];
                     state_q <= ST_RDATA;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end
            end
            default: begin
               oe_q <= 1'b0;
            end
         endcase
      end
   end

   assign sda_oe = oe_q;
endmodule

// File: rtl/i2c_evt_target_chk.sv
module i2c_evt_target_chk #(
   parameter int CW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          scl_s,
   input logic          stop_det,
   input logic          sda_oe,
   input logic          in_idle,
   input logic          evt_valid,
   input logic          pend_full,
   input logic          evt_ovf,
   input logic          hold,
   input logic          pop,
   input logic [CW-1:0] fifo_cnt
);
   AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !$past(scl_s));                                  // R1
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      in_idle |-> !sda_oe);                                              // R1
   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!sda_oe && in_idle));                                // R10
   AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !pop) |=> (fifo_cnt <= $past(fifo_cnt)));                 // R6
   AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && pend_full) |=> evt_ovf);                             // R7
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      evt_ovf |=> evt_ovf);                                              // R7
endmodule

bind i2c_evt_target i2c_evt_target_chk #(.CW(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
   .sda_oe(sda_oe), .in_idle(state_q == i2c_evt_pkg::ST_IDLE),
   .evt_valid(evt_valid), .pend_full(pend_full), .evt_ovf(evt_ovf),
   .hold(hold_q), .pop(pop_req), .fifo_cnt(fifo_cnt)
);

// File: tb/i2c_evt_target_tb.sv
module i2c_evt_target_tb;
   localparam int Q = 5;
   localparam logic [7:0] AW = 8'h68;   // 0x34 with write bit
   localparam logic [7:0] AR = 8'h69;   // 0x34 with read bit

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        scl_drv = 1'b1, sda_drv = 1'b1;
   logic        evt_valid = 1'b0;
   logic [7:0]  evt_data = '0;
   logic        sda_oe, evt_ovf, sda_line;
   logic [63:0] ctrl_q;
   int total = 0, bad = 0;

   assign sda_line = sda_drv & ~sda_oe;

   i2c_evt_target u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
      .sda_oe(sda_oe), .evt_valid(evt_valid), .evt_data(evt_data),
      .evt_ovf(evt_ovf), .ctrl_q(ctrl_q)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic qw(); repeat (Q) @(negedge clk); endtask

   task automatic bus_start();
      sda_drv = 1'b1; qw(); scl_drv = 1'b1; qw(); sda_drv = 1'b0; qw(); scl_drv = 1'b0; qw();
   endtask

   task automatic bus_stop();
      sda_drv = 1'b0; qw(); scl_drv = 1'b1; qw(); sda_drv = 1'b1; qw();
   endtask

   task automatic put_bit(input logic b);
      sda_drv = b; qw(); scl_drv = 1'b1; qw(); qw(); scl_drv = 1'b0; qw();
   endtask

   task automatic get_bit(output logic b);
      sda_drv = 1'b1; qw(); scl_drv = 1'b1; qw(); b = sda_line; qw(); scl_drv = 1'b0; qw();
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack_n);
      for (int i = 7; i >= 0; i--) put_bit(d[i]);
      get_bit(ack_n);
   endtask

   task automatic recv_byte(input logic ack, output logic [7:0] d);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         d[i] = b;
      end
      put_bit(!ack);
   endtask

   task automatic push_evt(input logic [7:0] d);
      @(negedge clk); evt_valid = 1'b1; evt_data = d;
      @(negedge clk); evt_valid = 1'b0;
   endtask

   task automatic wr_one(input logic [7:0] ptr, input logic [7:0] d);
      logic a;
      bus_start();
      send_byte(AW, a);  chk("R1 addr ack", a, 0);
      send_byte(ptr, a); chk("R2 ptr ack", a, 0);
      send_byte(d, a);   chk("R2 data ack", a, 0);
      bus_stop();
   endtask

   task automatic rd_one(input logic [7:0] ptr, output logic [7:0] d);
      logic a;
      bus_start();
      send_byte(AW, a);
      send_byte(ptr, a);
      bus_start();
      send_byte(AR, a); chk("R3 read addr ack", a, 0);
      recv_byte(1'b0, d);
      bus_stop();
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R9 sda released", sda_oe, 0);
      chk("R9 ovf low", evt_ovf, 0);
      chk("R9 regs zero", ctrl_q[31:0], 0);
      chk("R9 regs zero hi", ctrl_q[63:32], 0);
      rd_one(8'h00, d); chk("R9 fifo empty", d, 0);
   endtask

   task automatic t_write_single();
      logic [7:0] d;
      wr_one(8'h12, 8'hA5);
      chk("R2 single write", ctrl_q[23:16], 8'hA5);
      rd_one(8'h12, d); chk("R3 single read", d, 8'hA5);
   endtask

   task automatic t_multi();
      logic a;
      logic [7:0] d0, d1, d2;
      bus_start();
      send_byte(AW, a); send_byte(8'h14, a);
      send_byte(8'h11, a); chk("R2 burst ack0", a, 0);
      send_byte(8'h22, a); chk("R2 burst ack1", a, 0);
      send_byte(8'h33, a); chk("R2 burst ack2", a, 0);
      bus_stop();
      chk("R2 burst stored", ctrl_q[55:32], 24'h332211);
      bus_start();
      send_byte(AW, a); send_byte(8'h14, a);
      bus_start();
      send_byte(AR, a);
      recv_byte(1'b1, d0); recv_byte(1'b1, d1); recv_byte(1'b0, d2);
      bus_stop();
      chk("R3 burst read", {d0, d1, d2}, 24'h112233);
   endtask

   task automatic t_foreign();
      logic a;
      bus_start();
      send_byte(8'h6A, a); chk("R1 foreign addr nack", a, 1);
      send_byte(8'h10, a); chk("R1 silent after nack", a, 1);
      send_byte(8'hEE, a); chk("R1 silent data", a, 1);
      bus_stop();
      chk("R1 no store on foreign", ctrl_q[7:0], 0);
   endtask

   task automatic t_unmapped();
      logic [7:0] d;
      wr_one(8'h40, 8'h77);
      rd_one(8'h40, d); chk("R5 unmapped reads zero", d, 0);
      wr_one(8'h00, 8'h55);
      rd_one(8'h00, d); chk("R5 count read-only", d, 0);
   endtask

   task automatic t_events();
      logic [7:0] d;
      push_evt(8'h31); push_evt(8'h32); push_evt(8'h33);
      repeat (4) @(negedge clk);
      rd_one(8'h00, d); chk("R6 committed when free", d, 3);
      rd_one(8'h01, d); chk("R8 pop first", d, 8'h31);
      rd_one(8'h01, d); chk("R8 pop second", d, 8'h32);
      rd_one(8'h01, d); chk("R8 pop third", d, 8'h33);
      rd_one(8'h01, d); chk("R5 pop empty", d, 0);
      rd_one(8'h00, d); chk("R5 count drained", d, 0);
   endtask

   task automatic t_hold();
      logic a;
      logic [7:0] d;
      bus_start();
      send_byte(AW, a); send_byte(8'h00, a);
      push_evt(8'h41); push_evt(8'h42);
      repeat (4) @(negedge clk);
      bus_start();
      send_byte(AR, a);
      recv_byte(1'b0, d); chk("R6 count frozen", d, 0);
      bus_stop();
      repeat (4) @(negedge clk);
      rd_one(8'h00, d); chk("R6 applied after stop", d, 2);
      rd_one(8'h01, d); chk("R8 held order first", d, 8'h41);
      rd_one(8'h01, d); chk("R8 held order second", d, 8'h42);
   endtask

   task automatic t_nohold();
      logic a;
      logic [7:0] d;
      bus_start();
      send_byte(AW, a); send_byte(8'h10, a);
      push_evt(8'h51);
      repeat (4) @(negedge clk);
      bus_start();
      send_byte(AW, a); send_byte(8'h00, a);
      bus_start();
      send_byte(AR, a);
      recv_byte(1'b0, d); chk("R6 no hold without access", d, 1);
      bus_stop();
      rd_one(8'h01, d); chk("R8 pop after no-hold", d, 8'h51);
   endtask

   task automatic t_wrap();
      logic a;
      logic [7:0] d0, d1;
      push_evt(8'h61); push_evt(8'h62);
      repeat (4) @(negedge clk);
      bus_start();
      send_byte(AW, a); send_byte(8'hFF, a);
      bus_start();
      send_byte(AR, a);
      recv_byte(1'b1, d0); recv_byte(1'b0, d1);
      bus_stop();
      chk("R4 byte at 0xFF", d0, 0);
      chk("R4 wrap to count", d1, 2);
      rd_one(8'h01, d0); rd_one(8'h01, d1);
      chk("R8 drain after wrap", {d0, d1}, 16'h6162);
   endtask

   task automatic t_ovf();
      logic a;
      logic [7:0] d;
      chk("R7 ovf clear before", evt_ovf, 0);
      bus_start();
      send_byte(AW, a); send_byte(8'h01, a);
      for (int i = 0; i < 5; i++) push_evt(8'h71 + 8'(i));
      @(negedge clk);
      chk("R7 ovf set", evt_ovf, 1);
      bus_stop();
      repeat (6) @(negedge clk);
      rd_one(8'h00, d); chk("R7 four kept", d, 4);
      for (int i = 0; i < 4; i++) begin
         rd_one(8'h01, d); chk("R8 pop after overflow", d, 8'h71 + 8'(i));
      end
      chk("R7 ovf sticky", evt_ovf, 1);
   endtask

   task automatic t_abort();
      logic a;
      bus_start();
      send_byte(AW, a); send_byte(8'h10, a);
      put_bit(1); put_bit(0); put_bit(1); put_bit(1);
      bus_stop();
      chk("R10 stop drops byte", ctrl_q[7:0], 0);
      chk("R10 released after stop", sda_oe, 0);
      bus_start();
      send_byte(AW, a); send_byte(8'h11, a);
      put_bit(1); put_bit(1); put_bit(0); put_bit(0);
      bus_start();
      send_byte(AW, a); chk("R10 restart addr ack", a, 0);
      send_byte(8'h11, a); send_byte(8'h5A, a);
      bus_stop();
      chk("R10 restart write", ctrl_q[15:8], 8'h5A);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_write_single();
      t_multi();
      t_foreign();
      t_unmapped();
      t_events();
      t_hold();
      t_nohold();
      t_wrap();
      t_ovf();
      t_abort();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule